// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers the address of an incoming transaction to one of several destinations. Software programs a bank of address windows through a simple 32-bit register port. Each window has an enable, a 4-bit destination code, a base and an inclusive end, and four bits that refuse non-secure traffic of a given kind. The decoder is purely combinational from request to result. It returns a hit flag, the destination code and the number of the window that matched.

All window bounds are kept in 1 MB units. Window 0 always maps the configuration space. It is always active, and it covers exactly 16 MB starting at its programmed base. When several windows claim the same address, the lowest-numbered one wins. An address that no window accepts gives a miss, with destination 0 and index 0. The register map gives each window a 0x20-byte slot. It has no read strobe and no handshake: read data follows the register address combinationally, and writes land on the next rising clock edge.

Top module: `addr_window_router`

## Requirements
- R1: There are NUM_WIN windows (16 by default). Window w occupies the 0x20-byte slot starting at byte offset w*0x20, with the control word at +0x0, the security word at +0x4, the base word at +0x8 and the end word at +0xC. The remaining words of a slot read 0, and writing them has no effect.
- R2: In the control word, bit 0 is the enable and bits [11:8] are the destination code. All other bits read 0.
- R3: The base and end words carry request address bits [ADDR_W-1:20] in word bits [ADDR_W-17:4]. Bits [3:0] and all bits above the field read 0, whatever was written.
- R4: A window w >= 1 accepts an address whose 1 MB unit u meets base <= u <= end (inclusive), provided the window is enabled.
- R5: Window 0 is always enabled, and writes to its enable bit are ignored. It accepts units base <= u < base+16, and its end word does not affect matching.
- R6: Security word bits: bit 0 guards control-type writes, bit 1 control-type reads, bit 2 ordinary writes and bit 3 ordinary reads. When the bit for the request's kind is set and req_secure is 0, the window does not accept the request. Secure requests are never refused. Bits [31:4] read 0.
- R7: When several windows accept a request, hit=1 and target and win_idx come from the lowest-numbered accepting window.
- R8: When no window accepts a request, hit=0, target=0 and win_idx=0.
- R9: After reset, window 0 has destination 0 and base RESET_BASE_MB, and its security bits are 0. Every other window is disabled, with all fields 0.
- R10: reg_rdata shows the stored contents of the word addressed by reg_addr in the same cycle. A write with reg_we=1 is visible after the next rising clock edge, and reg_rdata stays put while there is no write and reg_addr is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | clog2(NUM_WIN)+5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_addr | input | ADDR_W | Request address |
| req_ctrl | input | 1 | Request is a control-type access |
| req_write | input | 1 | Request is a write (0 = read) |
| req_secure | input | 1 | Request carries the secure attribute |
| hit | output | 1 | A window accepted the request |
| target | output | 4 | Destination code of the selected window |
| win_idx | output | clog2(NUM_WIN) | Number of the selected window |

## Verification
The bench uses four windows and a 28-bit address. It sweeps every 1 MB unit against all eight combinations of control type, direction and security, and it alternates the low 20 address bits between all zeros and all ones.

The first sweep runs on the reset map. It separates the fixed 16 MB window 0 from the misses. A second sweep runs on a map built to stress the decoder: window 1 overlaps window 0, window 2 is a single unit, window 3 reaches the top unit, and each of windows 0, 2 and 3 guards a different access kind. This sweep separates priority, inclusive-end and security errors. A third sweep disables a window and moves window 0 to the top of the space, which tests its 16-unit limit at the wraparound edge.

Register readbacks with junk written into the unused bits test the masking of each word.

// File: rtl/awd_pkg.sv
// Shared constants for the address window decoder: register layout inside a
// window slot, field positions and the fixed size of window 0.
package awd_pkg;
    localparam int UNIT_SHIFT  = 20;   // 1 MB granularity
    localparam int SLOT_LG     = 5;    // 0x20 bytes per window
    localparam int FIELD_LSB   = 4;    // address field position in base/end words
    localparam int TGT_LSB     = 8;    // destination code position in control word
    localparam int TGT_W       = 4;
    localparam int SEC_W       = 4;
    localparam int WIN0_UNITS  = 16;   // 16 MB fixed span of window 0

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_SEC  = 3'd1;
    localparam logic [2:0] OFS_LOW  = 3'd2;
    localparam logic [2:0] OFS_HIGH = 3'd3;

    // Security bit that guards a request kind: control write 0, control read 1,
    // ordinary write 2, ordinary read 3.
    function automatic logic [1:0] sec_sel(input logic is_ctrl, input logic is_write);
        return {~is_ctrl, ~is_write};
    endfunction
endpackage

// File: rtl/awd_regs.sv
// Window register bank. Holds enable, destination, security bits, base and
// end for every window, and serves a combinational read of the addressed word.
// Assumes NUM_WIN >= 2 and UNIT_W + 4 <= 32.
module awd_regs
    import awd_pkg::*;
#(
    parameter int NUM_WIN       = 16,
    parameter int UNIT_W        = 20,
    parameter int RESET_BASE_MB = 0,
    parameter int REG_AW        = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    output logic [NUM_WIN-1:0]             win_en,
    output logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt,
    output logic [NUM_WIN-1:0][SEC_W-1:0]  win_sec,
    output logic [NUM_WIN-1:0][UNIT_W-1:0] win_base,
    output logic [NUM_WIN-1:0][UNIT_W-1:0] win_lim
);
    localparam int IDX_W = REG_AW - SLOT_LG;
    localparam logic [UNIT_W-1:0] RST_BASE = UNIT_W'(RESET_BASE_MB);

    logic [IDX_W-1:0] sel_win;
    logic [2:0]       sel_ofs;
    logic             win_ok;
    logic             unused_bits;

    assign sel_win     = reg_addr[REG_AW-1:SLOT_LG];
    assign sel_ofs     = reg_addr[4:2];
    assign win_ok      = int'(sel_win) < NUM_WIN;
    assign unused_bits = ^{reg_addr[1:0], reg_wdata};

    // Reset the map and apply register writes to the addressed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                win_en[i]   <= (i == 0);
                win_tgt[i]  <= '0;
                win_sec[i]  <= '0;
                win_base[i] <= (i == 0) ? RST_BASE : '0;
                win_lim[i]  <= '0;
            end
        end else if (reg_we && win_ok) begin
            case (sel_ofs)
                OFS_CTRL: begin
                    if (sel_win != '0) win_en[sel_win] <= reg_wdata[0];
                    win_tgt[sel_win] <= reg_wdata[TGT_LSB +: TGT_W];
                end
                OFS_SEC:  win_sec[sel_win]  <= reg_wdata[SEC_W-1:0];
                OFS_LOW:  win_base[sel_win] <= reg_wdata[FIELD_LSB +: UNIT_W];
                OFS_HIGH: win_lim[sel_win]  <= reg_wdata[FIELD_LSB +: UNIT_W];
                default:  ;
            endcase
        end
    end

    // Assemble the addressed word with all unused bits at zero.
    always_comb begin
        reg_rdata = '0;
        if (win_ok) begin
            case (sel_ofs)
                OFS_CTRL: begin
                    reg_rdata[0]                = win_en[sel_win];
                    reg_rdata[TGT_LSB +: TGT_W] = win_tgt[sel_win];
                end
                OFS_SEC:  reg_rdata[SEC_W-1:0]            = win_sec[sel_win];
                OFS_LOW:  reg_rdata[FIELD_LSB +: UNIT_W]  = win_base[sel_win];
                OFS_HIGH: reg_rdata[FIELD_LSB +: UNIT_W]  = win_lim[sel_win];
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/awd_match.sv
// One window comparator. Decides whether a request unit falls inside the
// window and is allowed by its security bits. FIXED_SIZE selects the 16-unit
// span from the base and ignores the end bound (window 0).
module awd_match
    import awd_pkg::*;
#(
    parameter int UNIT_W     = 20,
    parameter bit FIXED_SIZE = 1'b0
) (
    input  logic [UNIT_W-1:0] req_unit,
    input  logic              req_ctrl,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic              en,
    input  logic [SEC_W-1:0]  sec,
    input  logic [UNIT_W-1:0] base,
    input  logic [UNIT_W-1:0] lim,
    output logic              accept
);
    logic in_range;
    logic blocked;

    generate
        if (FIXED_SIZE) begin : g_fixed
            logic [UNIT_W:0] span_end;
            logic            unused_lim;
            assign unused_lim = ^lim;
            // Span end one past the last unit, one bit wider to survive wraparound.
            always_comb span_end = {1'b0, base} + (UNIT_W+1)'(WIN0_UNITS);
            // Half-open compare against the fixed span.
            always_comb in_range = (req_unit >= base) && ({1'b0, req_unit} < span_end);
        end else begin : g_prog
            // Inclusive compare against the programmed bounds.
            always_comb in_range = (req_unit >= base) && (req_unit <= lim);
        end
    endgenerate

    // Refuse non-secure traffic of a guarded kind.
    always_comb blocked = sec[sec_sel(req_ctrl, req_write)] & ~req_secure;

    // Final acceptance.
    always_comb accept = en & in_range & ~blocked;
endmodule

// File: rtl/awd_pick.sv
// Priority selector. Picks the lowest-numbered accepting window and returns
// its number and destination; outputs zero when no window accepts.
module awd_pick
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_WIN-1:0]            accept,
    input  logic [NUM_WIN-1:0][TGT_W-1:0] tgt,
    output logic                          any,
    output logic [IDX_W-1:0]              idx,
    output logic [TGT_W-1:0]              target
);
    // Scan from the top so the lowest accepting window is written last.
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        target = '0;
        for (int i = NUM_WIN-1; i >= 0; i--) begin
            if (accept[i]) begin
                any    = 1'b1;
                idx    = IDX_W'(i);
                target = tgt[i];
            end
        end
    end
endmodule

// File: rtl/addr_window_router.sv
// Programmable address window decoder top. Register bank, one comparator per
// window, and a priority selector. Request path is combinational; register
// writes take effect on the next clock. Assumes 24 <= ADDR_W <= 48.
module addr_window_router
    import awd_pkg::*;
#(
    parameter int NUM_WIN       = 16,
    parameter int ADDR_W        = 40,
    parameter int RESET_BASE_MB = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [$clog2(NUM_WIN)+4:0]   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic                         req_ctrl,
    input  logic                         req_write,
    input  logic                         req_secure,
    output logic                         hit,
    output logic [3:0]                   target,
    output logic [$clog2(NUM_WIN)-1:0]   win_idx
);
    localparam int IDX_W  = $clog2(NUM_WIN);
    localparam int REG_AW = IDX_W + SLOT_LG;
    localparam int UNIT_W = ADDR_W - UNIT_SHIFT;

    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt;
    logic [NUM_WIN-1:0][SEC_W-1:0]  win_sec;
    logic [NUM_WIN-1:0][UNIT_W-1:0] win_base;
    logic [NUM_WIN-1:0][UNIT_W-1:0] win_lim;
    logic [NUM_WIN-1:0]             accept;
    logic [UNIT_W-1:0]              req_unit;
    logic                           unused_low;

    assign req_unit   = req_addr[ADDR_W-1:UNIT_SHIFT];
    assign unused_low = ^req_addr[UNIT_SHIFT-1:0];

    awd_regs #(
        .NUM_WIN(NUM_WIN), .UNIT_W(UNIT_W),
        .RESET_BASE_MB(RESET_BASE_MB), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_en(win_en), .win_tgt(win_tgt), .win_sec(win_sec),
        .win_base(win_base), .win_lim(win_lim)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        awd_match #(.UNIT_W(UNIT_W), .FIXED_SIZE(i == 0)) u_match (
            .req_unit(req_unit), .req_ctrl(req_ctrl),
            .req_write(req_write), .req_secure(req_secure),
            .en(win_en[i]), .sec(win_sec[i]),
            .base(win_base[i]), .lim(win_lim[i]),
            .accept(accept[i])
        );
    end

    awd_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .accept(accept), .tgt(win_tgt),
        .any(hit), .idx(win_idx), .target(target)
    );
endmodule

// File: rtl/awd_chk.sv
// Assertion checker for addr_window_router, attached with bind. Observes the
// top-level ports only.
module awd_chk #(
    parameter int NUM_WIN = 16,
    parameter int ADDR_W  = 40
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_we,
    input logic [$clog2(NUM_WIN)+4:0] reg_addr,
    input logic [31:0]                reg_rdata,
    input logic                       hit,
    input logic [3:0]                 target,
    input logic [$clog2(NUM_WIN)-1:0] win_idx
);
    localparam int UNIT_W = ADDR_W - 20;
    localparam logic [31:0] FIELD_MASK = ((32'd1 << UNIT_W) - 32'd1) << 4;

    logic [2:0] ofs;
    logic       slot0;
    assign ofs   = reg_addr[4:2];
    assign slot0 = (reg_addr[$clog2(NUM_WIN)+4:5] == '0);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (target == 4'd0 && win_idx == '0));

    // R5
    win0_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0 && ofs == 3'd0) |-> reg_rdata[0]);

    // R2
    ctrl_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == 3'd0) |-> ((reg_rdata & 32'hFFFF_F0FE) == 32'd0));

    // R3
    addr_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == 3'd2 || ofs == 3'd3) |-> ((reg_rdata & ~FIELD_MASK) == 32'd0));

    // R6
    sec_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == 3'd1) |-> (reg_rdata[31:4] == 28'd0));

    // R1
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs >= 3'd4) |-> (reg_rdata == 32'd0));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(reg_addr) -> $stable(reg_rdata)));
endmodule

bind addr_window_router awd_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .hit(hit), .target(target), .win_idx(win_idx)
);

// File: tb/sim_addr_window_router.sv
// Bench: 4 windows, 28-bit addresses (256 units of 1 MB). Full unit sweeps
// against a requirement-level model kept in the bench.
module sim_addr_window_router;
    localparam int NW  = 4;
    localparam int AW  = 28;
    localparam int RB  = 8;
    localparam int RAW = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [AW-1:0]  req_addr = '0;
    logic           req_ctrl = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic           hit;
    logic [3:0]     target;
    logic [1:0]     win_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_en [NW];
    int m_tgt[NW];
    int m_sec[NW];
    int m_base[NW];
    int m_lim[NW];

    always #2.5 clk = ~clk;

    addr_window_router #(.NUM_WIN(NW), .ADDR_W(AW), .RESET_BASE_MB(RB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
        .req_ctrl(req_ctrl), .req_write(req_write), .req_secure(req_secure),
        .hit(hit), .target(target), .win_idx(win_idx)
    );

    task automatic wr(input int w, input int ofs, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RAW'(w * 32 + ofs); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int w, input int ofs, input logic [31:0] exp);
        reg_addr = RAW'(w * 32 + ofs);
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: win %0d ofs 0x%0h read 0x%08h expected 0x%08h", tag, w, ofs, reg_rdata, exp);
        end
    endtask

    // Program a window and track it in the model (window 0 stays enabled).
    task automatic prog(input int w, input int en, input int tg, input int sc, input int b, input int l);
        wr(w, 0, 32'((tg << 8) | en));
        wr(w, 4, 32'(sc));
        wr(w, 8, 32'(b << 4));
        wr(w, 12, 32'(l << 4));
        m_en[w] = (w == 0) ? 1 : en; m_tgt[w] = tg; m_sec[w] = sc; m_base[w] = b; m_lim[w] = l;
    endtask

    // Sweep every unit and request kind; R4 R5 R6 R7 R8 expectations.
    task automatic sweep(input string tag);
        for (int u = 0; u < 256; u++) begin
            for (int k = 0; k < 8; k++) begin
                bit eh; int ei, et;
                bit c, w, s;
                c = k[2]; w = k[1]; s = k[0];
                req_addr = {u[7:0], (u[0] ? 20'hFFFFF : 20'h00000)};
                req_ctrl = c; req_write = w; req_secure = s;
                eh = 0; ei = 0; et = 0;
                for (int i = NW-1; i >= 0; i--) begin
                    bit inr; int sb;
                    if (i == 0) inr = (u >= m_base[0]) && (u < m_base[0] + 16);
                    else        inr = (m_en[i] != 0) && (u >= m_base[i]) && (u <= m_lim[i]);
                    sb = (c ? 0 : 2) + (w ? 0 : 1);
                    if (inr && !(m_sec[i][sb] && !s)) begin eh = 1; ei = i; et = m_tgt[i]; end
                end
                #1;
                checks++;
                if (hit !== eh || int'(win_idx) != ei || int'(target) != et) begin
                    errors++;
                    $display("FAIL %s R4/R5/R6/R7/R8: unit %0d kind %0d got hit=%0b idx=%0d tgt=%0d expected hit=%0b idx=%0d tgt=%0d",
                             tag, u, k, hit, win_idx, target, eh, ei, et);
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_en[i] = (i == 0); m_tgt[i] = 0; m_sec[i] = 0; m_base[i] = (i == 0) ? RB : 0; m_lim[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset map
        rd_chk("R9", 0, 0, 32'h1);
        rd_chk("R9", 0, 8, 32'(RB << 4));
        rd_chk("R9", 0, 4, 32'h0);
        for (int i = 1; i < NW; i++) begin
            rd_chk("R9", i, 0, 32'h0);
            rd_chk("R9", i, 4, 32'h0);
            rd_chk("R9", i, 8, 32'h0);
            rd_chk("R9", i, 12, 32'h0);
        end
        sweep("reset map");

        // R5: enable write ignored, destination taken; end word ignored for matching
        wr(0, 0, 32'h0000_0200); m_tgt[0] = 2;
        rd_chk("R5 R10", 0, 0, 32'h0000_0201);
        wr(0, 12, 32'h0000_0010);
        wr(0, 4, 32'h1); m_sec[0] = 1;
        // R2 / R3 unused bits masked on write and read
        wr(1, 0, 32'hFFFF_F5F1);
        rd_chk("R2", 1, 0, 32'h0000_0501);
        wr(1, 8, 32'hFFFF_F04F);
        rd_chk("R3", 1, 8, 32'h0000_0040);
        wr(1, 12, 32'h0000_00C0);
        m_en[1] = 1; m_tgt[1] = 5; m_base[1] = 4; m_lim[1] = 12;
        wr(1, 4, 32'hFFFF_FFF0);
        rd_chk("R6", 1, 4, 32'h0);
        // R1: gap word reads zero and its write leaves the slot intact
        wr(1, 16, 32'hFFFF_FFFF);
        rd_chk("R1", 1, 16, 32'h0);
        rd_chk("R1", 1, 0, 32'h0000_0501);
        prog(2, 1, 7, 4'h4, 30, 30);
        prog(3, 1, 3, 4'h8, 40, 255);
        rd_chk("R1", 2, 12, 32'h0000_01E0);
        rd_chk("R1", 3, 4, 32'h8);
        sweep("programmed map");

        // Disable window 1, move window 0 to the top unit range
        wr(1, 0, 32'h0000_0500); m_en[1] = 0;
        rd_chk("R2", 1, 0, 32'h0000_0500);
        wr(0, 8, 32'h0000_0FA0); m_base[0] = 250;
        rd_chk("R10", 0, 8, 32'h0000_0FA0);
        sweep("moved map");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule